// File: doc/BRIEF.md
# ADC Single-Conversion Sequence Controller

This block is the digital control side of a successive-approximation converter. Software programs two independent channel lists through a small register port. The regular list has up to sixteen slots and the inserted list has up to four, and each list has its own length field. A conversion is requested by a software trigger bit or by an external trigger pin, with one pin per group. In single-conversion mode a regular request always converts the channel held in regular slot 0, and an inserted request always converts the channel held in the last inserted slot, slot 3.

Each conversion has two phases. A sample phase first runs for a programmable number of clock cycles. The controller then issues a one-cycle start pulse that carries the channel number, and waits for the converter's done pulse, which carries a 12-bit result. A regular result is captured into the regular data register and raises the end-of-conversion flag. When its interrupt enable is set, that flag drives the interrupt line. An inserted result goes to a separate inserted data register and touches neither the regular data nor the flag. A single enable bit gates the whole datapath: while it is 0 the controller is held in reset and tells the analog part to power down.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While CTRL[0] (enable, address 0x00) is 0, `power_down` is 1, triggers start nothing, and STAT, RDATA and IDATA read 0; clearing enable during a conversion abandons it, while CTRL and slot contents are kept.
- R2: A regular trigger (CTRL[2] written 1, or `ext_reg_trig` high at a clock edge) converts the channel in regular slot 0 (address 0x10, bits [4:0]); `conv_start` is high for exactly one cycle with that channel on `conv_ch`.
- R3: An inserted trigger (CTRL[3] written 1, or `ext_ins_trig`) converts the channel in inserted slot 3 (address 0x23, bits [4:0]), whatever the other slots hold.
- R4: With CTRL[15:8] = S, `conv_start` rises S+1 clock edges after the edge that samples an external trigger, and S+2 edges after the edge that commits a software-trigger write.
- R5: A done pulse ending a regular conversion stores `conv_result` in RDATA (address 0x02, bits [11:0]) and sets STAT[0] (end-of-conversion, address 0x01).
- R6: A done pulse ending an inserted conversion stores the result in IDATA (address 0x03) and leaves RDATA and STAT[0] unchanged.
- R7: `irq` equals STAT[0] AND CTRL[1] (interrupt enable).
- R8: STAT[0] is cleared by writing STAT with bit 0 equal to 0, or by a read strobe (`rd_en`) at address 0x02.
- R9: A trigger that arrives while STAT[1] (busy) is 1 is dropped; each conversion produces exactly one start pulse, and busy returns to 0 once done is taken.
- R10: When regular and inserted triggers arrive in the same idle cycle, only the inserted conversion runs.
- R11: LEN (address 0x04) keeps a 4-bit regular length in bits [3:0] and a 2-bit inserted length in bits [9:8]; slot registers keep 5 bits; all other bits read 0.
- R12: A done pulse while no conversion is waiting for one changes neither RDATA, IDATA nor STAT[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe (side effect on RDATA) |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| ext_reg_trig | input | 1 | External regular trigger |
| ext_ins_trig | input | 1 | External inserted trigger |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_ch | output | 5 | Channel number for the conversion |
| conv_done | input | 1 | Converter done pulse |
| conv_result | input | 12 | Converter result, valid with done |
| power_down | output | 1 | Analog power-down request |
| irq | output | 1 | End-of-conversion interrupt |

## Verification
The bench uses the default parameters: 18 channels, 16 regular and 4 inserted slots, and a 12-bit result. Every channel number is therefore swept through both regular slot 0 and inserted slot 3, with the other slots loaded with decoy channels. Sample lengths 0 to 3 and converter latencies 1 to 3 are cycled across the sweep, so the start-timing rule is checked for each pairing. Expected results come from an arithmetic function of the channel and a per-run seed. Further cases cover overlapping triggers, simultaneous triggers, stray done pulses and disabling the block mid-conversion.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NUM_CH    = 18,
  parameter int REG_SLOTS = 16,
  parameter int INS_SLOTS = 4,
  parameter int RES_W     = 12,
  parameter int SMP_W     = 8,
  parameter int DW        = 32,
  parameter int AW        = 6,
  localparam int CH_W     = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic             ext_reg_trig,
  input  logic             ext_ins_trig,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_ch,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             power_down,
  output logic             irq
);
  localparam int RL_W = $clog2(REG_SLOTS);
  localparam int IL_W = $clog2(INS_SLOTS);
  localparam logic [AW-1:0] A_CTRL = 6'h00;
  localparam logic [AW-1:0] A_STAT = 6'h01;
  localparam logic [AW-1:0] A_RDAT = 6'h02;
  localparam logic [AW-1:0] A_IDAT = 6'h03;
  localparam logic [AW-1:0] A_LEN  = 6'h04;

  typedef enum logic [1:0] {S_IDLE, S_SMP, S_CNV} st_t;

  logic             en, ie;
  logic [SMP_W-1:0] smp;
  logic [RL_W-1:0]  rlen;
  logic [IL_W-1:0]  ilen;
  logic [CH_W-1:0]  rslot [REG_SLOTS];
  logic [CH_W-1:0]  islot [INS_SLOTS];
  logic             sw_r, sw_i;
  st_t              st;
  logic [SMP_W-1:0] cnt;
  logic             grp_ins;
  logic [CH_W-1:0]  ch_q;
  logic             start_q;
  logic             eoc;
  logic [RES_W-1:0] rdat, idat;

  wire wr_ctrl  = wr_en && wr_addr == A_CTRL;
  wire wr_stat  = wr_en && wr_addr == A_STAT;
  wire wr_len   = wr_en && wr_addr == A_LEN;
  wire wr_rslot = wr_en && wr_addr[AW-1:4] == 2'd1 && {1'b0, wr_addr[3:0]} < 5'(REG_SLOTS);
  wire wr_islot = wr_en && wr_addr[AW-1:4] == 2'd2 && {1'b0, wr_addr[3:0]} < 5'(INS_SLOTS);
  wire rd_rslot = rd_addr[AW-1:4] == 2'd1 && {1'b0, rd_addr[3:0]} < 5'(REG_SLOTS);
  wire rd_islot = rd_addr[AW-1:4] == 2'd2 && {1'b0, rd_addr[3:0]} < 5'(INS_SLOTS);

  wire busy     = st != S_IDLE;
  wire trg_r    = sw_r || ext_reg_trig;
  wire trg_i    = sw_i || ext_ins_trig;
  wire acc      = st == S_CNV && conv_done;
  wire done_reg = acc && !grp_ins;
  wire rd_clear = rd_en && rd_addr == A_RDAT;
  wire wr_clear = wr_stat && !wr_data[0];

  assign conv_start = start_q;
  assign conv_ch    = ch_q;
  assign power_down = !en;
  assign irq        = eoc && ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      ie   <= 1'b0;
      smp  <= '0;
      rlen <= '0;
      ilen <= '0;
      for (int i = 0; i < REG_SLOTS; i++) rslot[i] <= '0;
      for (int j = 0; j < INS_SLOTS; j++) islot[j] <= '0;
    end else begin
      if (wr_ctrl) begin
        en  <= wr_data[0];
        ie  <= wr_data[1];
        smp <= wr_data[8 +: SMP_W];
      end
      if (wr_len) begin
        rlen <= wr_data[RL_W-1:0];
        ilen <= wr_data[8 +: IL_W];
      end
      if (wr_rslot) rslot[wr_addr[RL_W-1:0]] <= wr_data[CH_W-1:0];
      if (wr_islot) islot[wr_addr[IL_W-1:0]] <= wr_data[CH_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_r <= 1'b0;
      sw_i <= 1'b0;
    end else begin
      sw_r <= wr_ctrl && wr_data[2];
      sw_i <= wr_ctrl && wr_data[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      grp_ins <= 1'b0;
      ch_q    <= '0;
      start_q <= 1'b0;
      eoc     <= 1'b0;
      rdat    <= '0;
      idat    <= '0;
    end else if (!en) begin
      st      <= S_IDLE;
      cnt     <= '0;
      grp_ins <= 1'b0;
      ch_q    <= '0;
      start_q <= 1'b0;
      eoc     <= 1'b0;
      rdat    <= '0;
      idat    <= '0;
    end else begin
      start_q <= st == S_SMP && cnt == smp;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (trg_i) begin
            st      <= S_SMP;
            grp_ins <= 1'b1;
            ch_q    <= islot[INS_SLOTS-1];
          end else if (trg_r) begin
            st      <= S_SMP;
            grp_ins <= 1'b0;
            ch_q    <= rslot[0];
          end
        end
        S_SMP: begin
          if (cnt == smp) st <= S_CNV;
          else cnt <= cnt + 1'b1;
        end
        S_CNV: begin
          if (conv_done) begin
            st <= S_IDLE;
            if (grp_ins) idat <= conv_result;
            else rdat <= conv_result;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (done_reg) eoc <= 1'b1;
      else if (rd_clear || wr_clear) eoc <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_rslot) rd_data[CH_W-1:0] = rslot[rd_addr[RL_W-1:0]];
    else if (rd_islot) rd_data[CH_W-1:0] = islot[rd_addr[IL_W-1:0]];
    else begin
      case (rd_addr)
        A_CTRL: begin
          rd_data[0]           = en;
          rd_data[1]           = ie;
          rd_data[8 +: SMP_W]  = smp;
        end
        A_STAT: begin
          rd_data[0] = eoc;
          rd_data[1] = busy;
        end
        A_RDAT: rd_data[RES_W-1:0] = rdat;
        A_IDAT: rd_data[RES_W-1:0] = idat;
        A_LEN: begin
          rd_data[RL_W-1:0]  = rlen;
          rd_data[8 +: IL_W] = ilen;
        end
        default: rd_data = '0;
      endcase
    end
  end
endmodule

module adc_seq_ctrl_chk #(
  parameter int CH_W  = 5,
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             power_down,
  input logic             conv_start,
  input logic [CH_W-1:0]  conv_ch,
  input logic             conv_done,
  input logic             irq,
  input logic             eoc,
  input logic             busy,
  input logic             acc,
  input logic             grp_ins,
  input logic [RES_W-1:0] rdat,
  input logic [RES_W-1:0] idat
);
  p_pd_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> !conv_start && !irq);
  p_ch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(conv_ch));
  p_eoc_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && en && !grp_ins |=> eoc);
  p_ins_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && en && grp_ins |=> $stable(rdat) && $stable(eoc));
  p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> eoc);
  p_one_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);
  p_stray_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && !busy && en |=> $stable(rdat) && $stable(idat));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CH_W(CH_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .power_down(power_down),
  .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
  .irq(irq), .eoc(eoc), .busy(busy), .acc(acc), .grp_ins(grp_ins),
  .rdat(rdat), .idat(idat)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  localparam logic [5:0] A_CTRL = 6'h00, A_STAT = 6'h01, A_RDAT = 6'h02,
                         A_IDAT = 6'h03, A_LEN = 6'h04, A_RS = 6'h10, A_IS = 6'h20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic ext_reg_trig = 1'b0, ext_ins_trig = 1'b0;
  logic conv_start, power_down, irq;
  logic [4:0] conv_ch;
  logic model_done = 1'b0, stray_done = 1'b0;
  logic conv_done;
  logic [11:0] conv_result = '0;

  int n_chk = 0, n_fail = 0, starts = 0, lat = 1, seed = 0;

  assign conv_done = model_done | stray_done;

  always #2 clk = ~clk;

  adc_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ext_reg_trig(ext_reg_trig), .ext_ins_trig(ext_ins_trig),
    .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
    .conv_result(conv_result), .power_down(power_down), .irq(irq)
  );

  function automatic logic [11:0] res_of(input int ch, input int s);
    return 12'((ch * 197 + s * 53 + 11) % 4096);
  endfunction

  always @(negedge clk) if (conv_start) starts++;

  initial begin
    forever begin
      @(negedge clk);
      if (conv_start) begin
        automatic int c = int'(conv_ch);
        repeat (lat) @(negedge clk);
        conv_result = res_of(c, seed);
        model_done  = 1'b1;
        @(negedge clk);
        model_done  = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic rd_strobe(output logic [31:0] d);
    @(negedge clk);
    rd_addr = A_RDAT; rd_en = 1'b1;
    #1 d = rd_data;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic count_to_start(output int n, output logic [4:0] ch);
    n = 0; ch = '0;
    for (int k = 0; k < 300; k++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (conv_start) begin ch = conv_ch; break; end
    end
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 200; k++) begin
      rd(A_STAT, s);
      if (!s[1]) break;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog (all requirements) act=hung exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, rprev;
    int n, s0;
    logic [4:0] ch;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    chk("R1 reset power_down", 32'(power_down), 32'd1);
    chk("R7 reset irq", 32'(irq), 32'd0);
    rd(A_STAT, d); chk("R1 reset STAT", d, 32'd0);
    rd(A_RDAT, d); chk("R1 reset RDATA", d, 32'd0);

    s0 = starts;
    @(negedge clk); ext_reg_trig = 1'b1; ext_ins_trig = 1'b1;
    @(negedge clk); ext_reg_trig = 1'b0; ext_ins_trig = 1'b0;
    wr(A_CTRL, 32'h4);
    repeat (10) @(negedge clk);
    chk("R1 triggers ignored while disabled", 32'(starts - s0), 32'd0);

    wr(A_LEN, 32'hFFFF_FFFF);
    rd(A_LEN, d); chk("R11 length fields", d, 32'h0000_030F);
    wr(A_RS + 6'd5, 32'hFFFF_FFFF);
    rd(A_RS + 6'd5, d); chk("R11 slot width", d, 32'h1F);

    for (int c = 0; c < 18; c++) begin
      automatic int sm = c % 4;
      automatic int ie = c % 2;
      lat = 1 + c % 3; seed = c;
      wr(A_RS, 32'(c));
      wr(A_RS + 6'd1, 32'((c + 5) % 18));
      wr(A_CTRL, 32'(sm << 8) | 32'(ie << 1) | 32'd1);
      chk("R1 enabled power_down", 32'(power_down), 32'd0);
      s0 = starts;
      @(negedge clk); ext_reg_trig = 1'b1;
      @(posedge clk); #1 ext_reg_trig = 1'b0;
      count_to_start(n, ch);
      chk("R4 sample length ext", 32'(n), 32'(sm + 1));
      chk("R2 regular slot0 channel", 32'(ch), 32'(c));
      wait_idle();
      rd(A_RDAT, d); chk("R5 RDATA", d, 32'(res_of(c, c)));
      rd(A_STAT, d); chk("R5 EOC set", d, 32'd1);
      chk("R7 irq follows enable", 32'(irq), 32'(ie));
      chk("R9 one start", 32'(starts - s0), 32'd1);
      if (c % 2 == 0) rd_strobe(d);
      else wr(A_STAT, 32'd0);
      rd(A_STAT, d); chk("R8 EOC cleared", d, 32'd0);
      chk("R7 irq low after clear", 32'(irq), 32'd0);
    end

    rd(A_RDAT, rprev);
    wr(A_CTRL, 32'h0000_0103);
    for (int c = 0; c < 18; c++) begin
      lat = 1 + c % 3; seed = c + 40;
      wr(A_IS + 6'd3, 32'(c));
      wr(A_IS, 32'((c + 7) % 18));
      wr(A_IS + 6'd2, 32'((c + 3) % 18));
      @(negedge clk); ext_ins_trig = 1'b1;
      @(posedge clk); #1 ext_ins_trig = 1'b0;
      count_to_start(n, ch);
      chk("R3 inserted slot3 channel", 32'(ch), 32'(c));
      chk("R4 sample length ins", 32'(n), 32'd2);
      wait_idle();
      rd(A_IDAT, d); chk("R6 IDATA", d, 32'(res_of(c, c + 40)));
      rd(A_RDAT, d); chk("R6 RDATA untouched", d, rprev);
      rd(A_STAT, d); chk("R6 EOC untouched", d, 32'd0);
    end

    lat = 2; seed = 7;
    wr(A_RS, 32'd9);
    wr(A_CTRL, 32'h0000_0207);
    count_to_start(n, ch);
    chk("R4 sample length sw", 32'(n), 32'd4);
    chk("R2 sw regular channel", 32'(ch), 32'd9);
    wait_idle();
    rd(A_RDAT, d); chk("R5 RDATA sw", d, 32'(res_of(9, 7)));
    wr(A_STAT, 32'd0);

    lat = 20; seed = 3;
    wr(A_RS, 32'd4);
    wr(A_IS + 6'd3, 32'd13);
    wr(A_CTRL, 32'h0000_0001);
    s0 = starts;
    @(negedge clk); ext_reg_trig = 1'b1;
    @(posedge clk); #1 ext_reg_trig = 1'b0;
    repeat (6) @(negedge clk);
    ext_ins_trig = 1'b1; ext_reg_trig = 1'b1;
    @(negedge clk); ext_ins_trig = 1'b0; ext_reg_trig = 1'b0;
    wr(A_CTRL, 32'h0000_000D);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R9 busy triggers dropped", 32'(starts - s0), 32'd1);
    rd(A_RDAT, d); chk("R9 first result kept", d, 32'(res_of(4, 3)));
    rd(A_STAT, d); chk("R9 back to idle", d, 32'd1);
    wr(A_STAT, 32'd0);

    lat = 1; seed = 5;
    s0 = starts;
    @(negedge clk); ext_reg_trig = 1'b1; ext_ins_trig = 1'b1;
    @(posedge clk); #1 ext_reg_trig = 1'b0; ext_ins_trig = 1'b0;
    count_to_start(n, ch);
    chk("R10 inserted wins", 32'(ch), 32'd13);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R10 regular dropped", 32'(starts - s0), 32'd1);
    rd(A_STAT, d); chk("R10 EOC stays clear", d, 32'd0);

    rd(A_RDAT, rprev);
    @(negedge clk); conv_result = 12'hABC; stray_done = 1'b1;
    @(negedge clk); stray_done = 1'b0;
    rd(A_RDAT, d); chk("R12 stray done RDATA", d, rprev);
    rd(A_IDAT, d); chk("R12 stray done IDATA", d, 32'(res_of(13, 5)));
    rd(A_STAT, d); chk("R12 stray done EOC", d, 32'd0);

    lat = 30; seed = 9;
    wr(A_CTRL, 32'h0000_0303);
    @(negedge clk); ext_reg_trig = 1'b1;
    @(posedge clk); #1 ext_reg_trig = 1'b0;
    repeat (8) @(negedge clk);
    wr(A_CTRL, 32'h0000_0300);
    @(negedge clk);
    chk("R1 power_down on disable", 32'(power_down), 32'd1);
    rd(A_STAT, d); chk("R1 STAT cleared", d, 32'd0);
    rd(A_RDAT, d); chk("R1 RDATA cleared", d, 32'd0);
    rd(A_IDAT, d); chk("R1 IDATA cleared", d, 32'd0);
    rd(A_CTRL, d); chk("R1 CTRL kept", d, 32'h0000_0300);
    rd(A_RS, d); chk("R1 slot kept", d, 32'd4);
    wr(A_CTRL, 32'h0000_0303);
    repeat (40) @(negedge clk);
    rd(A_STAT, d); chk("R12 late done after abandon", d, 32'd0);
    chk("R7 irq low after abandon", 32'(irq), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule